// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block forms the 106-bit unsigned product of two 53-bit operands. It uses one 53-bit adder and takes many clock cycles. A 106-bit accumulator holds the partial product. On each step the adder adds the multiplicand to a 53-bit window of that accumulator. The window starts at bit 0 and moves up by one bit per step. The multiplier sits in a shift register, and its lowest bit decides whether the step adds anything.

A single-cycle `start` pulse captures both operands and the mode bit. The same pulse clears the accumulator, the step counter and `done`, so a new operation needs no reset. Two modes are available:

- **Fixed-length mode:** every operation takes the same number of cycles.
- **Early-exit mode:** the run stops as soon as no set multiplier bits remain, so small multipliers finish sooner.

When the result is ready, `done` goes high. The product is then held until the next start.

Top module: `seq_shadd_mul`

## Requirements
- R1: While `rst_n` is low, and after it is released with no start, `done` is 0 and `product` is 0.
- R2: In the cycle after a clock edge that samples `start` high, `done` is 0 and `product` is 0. This holds even if a previous result was showing.
- R3: When `done` is high, `product` equals `mcand_in * mplr_in`, the full 106-bit unsigned product of the values sampled at the start edge. This includes zero, one and all-ones operands.
- R4: In fixed-length mode (`quick_en` = 0 at start), `done` rises exactly 54 rising edges after the start edge, whatever the multiplier value. The internal step count never exceeds 53.
- R5: In early-exit mode (`quick_en` = 1 at start), let k be the index of the highest set bit of the multiplier. `done` rises k+2 edges after the start edge, or 1 edge after it when the multiplier is zero. This is never later than the fixed-length latency.
- R6: Once `done` is high, `done` stays high and `product` stays unchanged until the next start. Operand and mode inputs have no effect in the meantime.
- R7: A start that arrives while an operation is running abandons it. Result and latency then follow the new operands, counted from the new start edge.
- R8: Operands and mode are sampled only at the start edge. Changing them on later cycles of a run does not alter the result or the latency.
- R9: For the same multiplier, the mode bit sampled at start selects between the R4 latency and the R5 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with `clk` |
| start | input | 1 | One-cycle pulse that loads operands and mode and begins a run |
| quick_en | input | 1 | Mode sampled at start: 1 = early exit, 0 = fixed length |
| mcand_in | input | 53 | Multiplicand, sampled at start |
| mplr_in | input | 53 | Multiplier, sampled at start |
| product | output | 106 | Accumulator; holds the full product while `done` is high |
| done | output | 1 | High from result-ready until the next start |

## Verification
The result timing counts from the edge that samples `start`. On the next falling edge, `done` and `product` must already be cleared. `done` must then first be seen after edge 54 in fixed-length mode, or after edge k+2 (edge 1 for a zero multiplier) in early-exit mode.

The bench samples on falling edges and counts edges from the start edge until `done` appears. It compares that count against the latency formula, which it computes on its own from the multiplier. It then compares `product` with a behavioural full-width multiply.

The bench drives random values onto the operand and mode inputs throughout every run and after completion. This shows that neither the result nor the latency depends on them. The checker measures the same start-to-done distance with its own counter, so the edge count is verified in two places.

// File: rtl/sam_pkg.sv
package sam_pkg;

  // Control phases of one multiplication.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,   // after reset, before any start
    ST_RUN  = 2'd1,   // stepping through multiplier bits
    ST_DONE = 2'd2    // result held until the next start
  } sam_state_e;

endpackage

// File: rtl/sam_window_add.sv
// Plain behavioural adder used on the sliding accumulator window.
module sam_window_add #(
  parameter int unsigned OP_W = 53
) (
  input  logic [OP_W-1:0] add_a,
  input  logic [OP_W-1:0] add_b,
  input  logic            add_ci,
  output logic [OP_W-1:0] add_sum,
  output logic            add_co
);

  localparam int unsigned SUM_W = OP_W + 1;

  logic [SUM_W-1:0] wide_sum;

  always_comb begin
    wide_sum = {1'b0, add_a} + {1'b0, add_b} + SUM_W'(add_ci);
    add_sum  = wide_sum[OP_W-1:0];
    add_co   = wide_sum[OP_W];
  end

endmodule

// File: rtl/sam_seq_ctrl.sv
// Sequencer: multiplier shift register, step counter, mode latch, phase.
module sam_seq_ctrl
  import sam_pkg::*;
#(
  parameter int unsigned OP_W  = 53,
  parameter int unsigned CNT_W = $clog2(OP_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             quick_en,
  input  logic [OP_W-1:0]  mplr_in,
  output logic             add_en,
  output logic [CNT_W-1:0] step_cnt,
  output logic             quick_lat,
  output logic             done
);

  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(OP_W);

  sam_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q,   cnt_d;
  logic [OP_W-1:0]  shift_q, shift_d;
  logic             quick_q, quick_d;

  logic             running;
  logic             finish;
  logic             step_en;
  logic             upd_en;

  // Decide what this cycle does.
  always_comb begin
    running = (state_q == ST_RUN);
    finish  = running && !start &&
              ((quick_q && (shift_q == '0)) || (cnt_q == LAST_STEP));
    step_en = running && !start && !finish;
    upd_en  = start || finish || step_en;
  end

  // Next-state computation.
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    quick_d = quick_q;
    if (start) begin
      state_d = ST_RUN;
      cnt_d   = '0;
      shift_d = mplr_in;
      quick_d = quick_en;
    end else if (finish) begin
      state_d = ST_DONE;
    end else if (step_en) begin
      cnt_d   = cnt_q + CNT_W'(1);
      shift_d = shift_q >> 1;
    end
  end

  // Registers with an explicit clock enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      quick_q <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      quick_q <= quick_d;
    end
  end

  assign add_en    = step_en && shift_q[0];
  assign step_cnt  = cnt_q;
  assign quick_lat = quick_q;
  assign done      = (state_q == ST_DONE);

endmodule

// File: rtl/sam_accum.sv
// Product accumulator with a 53-bit window that slides with the step count.
module sam_accum #(
  parameter int unsigned OP_W  = 53,
  parameter int unsigned CNT_W = $clog2(OP_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [OP_W-1:0]   mcand_in,
  input  logic              add_en,
  input  logic [CNT_W-1:0]  step_cnt,
  output logic [2*OP_W-1:0] prod
);

  localparam int unsigned PROD_W = 2 * OP_W;
  localparam int unsigned IDX_W  = $clog2(PROD_W);

  logic [OP_W-1:0]   mcand_q, mcand_d;
  logic [PROD_W-1:0] acc_q,   acc_d;
  logic [IDX_W-1:0]  lo_idx;
  logic [IDX_W-1:0]  hi_idx;
  logic [OP_W-1:0]   window;
  logic [OP_W-1:0]   win_sum;
  logic              win_co;
  logic              acc_en;
  logic              mcand_en;

  // Window bounds: lo = step, hi = step + OP_W (reaches PROD_W-1 at most).
  always_comb begin
    lo_idx = IDX_W'(step_cnt);
    hi_idx = lo_idx + IDX_W'(OP_W);
    window = acc_q[lo_idx +: OP_W];
  end

  sam_window_add #(.OP_W(OP_W)) add_i (
    .add_a   (mcand_q),
    .add_b   (window),
    .add_ci  (1'b0),
    .add_sum (win_sum),
    .add_co  (win_co)
  );

  always_comb begin
    mcand_en = clr;
    mcand_d  = mcand_in;
    acc_en   = clr || add_en;
    acc_d    = acc_q;
    if (clr) begin
      acc_d = '0;
    end else if (add_en) begin
      acc_d[lo_idx +: OP_W] = win_sum;
      acc_d[hi_idx]         = win_co;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
    end else if (mcand_en) begin
      mcand_q <= mcand_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign prod = acc_q;

endmodule

// File: rtl/seq_shadd_mul.sv
// Top: sequential shift-add multiplier with optional early exit.
module seq_shadd_mul #(
  parameter int unsigned OP_W = 53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              quick_en,
  input  logic [OP_W-1:0]   mcand_in,
  input  logic [OP_W-1:0]   mplr_in,
  output logic [2*OP_W-1:0] product,
  output logic              done
);

  localparam int unsigned CNT_W = $clog2(OP_W + 1);

  logic             add_en;
  logic [CNT_W-1:0] step_cnt;
  logic             quick_lat;

  sam_seq_ctrl #(.OP_W(OP_W), .CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .quick_en  (quick_en),
    .mplr_in   (mplr_in),
    .add_en    (add_en),
    .step_cnt  (step_cnt),
    .quick_lat (quick_lat),
    .done      (done)
  );

  sam_accum #(.OP_W(OP_W), .CNT_W(CNT_W)) accum_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start),
    .mcand_in (mcand_in),
    .add_en   (add_en),
    .step_cnt (step_cnt),
    .prod     (product)
  );

endmodule

// File: rtl/sam_checker.sv
module sam_checker #(
  parameter int unsigned OP_W  = 53,
  parameter int unsigned CNT_W = $clog2(OP_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic [2*OP_W-1:0] product,
  input logic [CNT_W-1:0]  step_cnt,
  input logic              quick_lat
);

  localparam int unsigned RC_W = CNT_W + 2;
  localparam logic [RC_W-1:0] RC_MAX = '1;

  // Edges since the last start, frozen once done is high.
  logic [RC_W-1:0] run_cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cyc_q <= '0;
    end else if (start) begin
      run_cyc_q <= '0;
    end else if (!done && (run_cyc_q != RC_MAX)) begin
      run_cyc_q <= run_cyc_q + RC_W'(1);
    end
  end

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);                                             // R2
  AST_START_CLEARS_PROD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (product == '0));                                   // R2
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(product)));             // R6
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step_cnt <= CNT_W'(OP_W));                                    // R4
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !quick_lat) |-> (run_cyc_q == RC_W'(OP_W + 1))); // R4
  AST_EARLY_NOT_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && quick_lat) |-> (run_cyc_q <= RC_W'(OP_W + 1)));  // R5

endmodule

bind seq_shadd_mul sam_checker #(.OP_W(OP_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .done      (done),
  .product   (product),
  .step_cnt  (step_cnt),
  .quick_lat (quick_lat)
);

// File: tb/seq_shadd_mul_tb.sv
module seq_shadd_mul_tb_top;

  localparam int unsigned OP_W   = 53;
  localparam int unsigned PROD_W = 2 * OP_W;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 11;
  localparam logic [OP_W-1:0] ONES = '1;

  localparam logic [OP_W-1:0] TAB_X [NV] = '{
    53'h0, 53'h0, 53'h1, ONES, ONES,
    53'h123456789ABCD, 53'h1DEADBEEF1234, 53'h0F0F0F0F0F0F0,
    ONES, 53'h13579BDF02468, 53'h1DEADBEEF1234};
  localparam logic [OP_W-1:0] TAB_Y [NV] = '{
    53'h0, ONES, 53'h1, ONES, ONES,
    53'h0FEDCBA987654, 53'h5, 53'h1,
    53'h0, 53'h10000000000000, 53'h5};
  localparam logic TAB_Q [NV] = '{
    1'b0, 1'b1, 1'b0, 1'b0, 1'b1,
    1'b0, 1'b1, 1'b1,
    1'b1, 1'b1, 1'b0};

  logic              clk;
  logic              rst_n;
  logic              start;
  logic              quick_en;
  logic [OP_W-1:0]   mcand_in;
  logic [OP_W-1:0]   mplr_in;
  logic [PROD_W-1:0] product;
  logic              done;

  int n_total;
  int n_bad;
  logic [63:0] lfsr;

  seq_shadd_mul #(.OP_W(OP_W)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .quick_en (quick_en),
    .mcand_in (mcand_in),
    .mplr_in  (mplr_in),
    .product  (product),
    .done     (done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [PROD_W-1:0] act, input logic [PROD_W-1:0] exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Put noise on the operand and mode inputs (start untouched).
  task automatic scramble();
    lfsr     = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
    mcand_in = lfsr[52:0];
    mplr_in  = lfsr[63:11];
    quick_en = lfsr[5];
  endtask

  function automatic int exp_latency(input logic [OP_W-1:0] y, input logic q);
    int msb;
    if (!q) return OP_W + 1;
    if (y == '0) return 1;
    msb = 0;
    for (int i = 0; i < OP_W; i++) if (y[i]) msb = i;
    return msb + 2;
  endfunction

  task automatic start_op(input logic [OP_W-1:0] x, input logic [OP_W-1:0] y,
                          input logic q);
    @(negedge clk);
    start    = 1'b1;
    mcand_in = x;
    mplr_in  = y;
    quick_en = q;
    @(negedge clk);
    start = 1'b0;
    scramble();
    chk(done == 1'b0, "R2", "done after start", PROD_W'(done), '0);
    chk(product == '0, "R2", "product after start", product, '0);
  endtask

  task automatic finish_op(input logic [OP_W-1:0] x, input logic [OP_W-1:0] y,
                           input logic q, input string tag);
    int cyc;
    logic [PROD_W-1:0] exp_p;
    logic [PROD_W-1:0] held;
    int exp_l;
    exp_p = {{OP_W{1'b0}}, x} * {{OP_W{1'b0}}, y};
    exp_l = exp_latency(y, q);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      scramble();
    end while (!done && cyc < 300);
    chk(done == 1'b1, tag, "done seen", PROD_W'(done), PROD_W'(1));
    chk(cyc == exp_l, q ? "R5 R9" : "R4 R9", {tag, " latency"},
        PROD_W'(cyc), PROD_W'(exp_l));
    chk(product == exp_p, "R3 R8", {tag, " product"}, product, exp_p);
    held = product;
    repeat (4) begin
      @(negedge clk);
      scramble();
    end
    chk(done == 1'b1 && product == held, "R6", {tag, " hold"}, product, held);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_total++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    n_total  = 0;
    n_bad    = 0;
    lfsr     = 64'h0123_4567_89AB_CDEF;
    rst_n    = 1'b0;
    start    = 1'b0;
    quick_en = 1'b0;
    mcand_in = '0;
    mplr_in  = '0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && product == '0, "R1", "in reset", product, '0);
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      scramble();
    end
    chk(done == 1'b0 && product == '0, "R1", "idle after reset", product, '0);

    // Vector table.
    for (int v = 0; v < NV; v++) begin
      start_op(TAB_X[v], TAB_Y[v], TAB_Q[v]);
      finish_op(TAB_X[v], TAB_Y[v], TAB_Q[v], $sformatf("vec%0d", v));
    end

    // R7: restart in the middle of a run.
    start_op(ONES, ONES, 1'b0);
    repeat (20) begin
      @(negedge clk);
      scramble();
    end
    chk(done == 1'b0, "R7", "busy before restart", PROD_W'(done), '0);
    start_op(53'h3, 53'h5, 1'b0);
    finish_op(53'h3, 53'h5, 1'b0, "R7 restart");

    // R7: restart in early-exit mode aborting a fixed run.
    start_op(53'h1ABCDEF, ONES, 1'b0);
    repeat (7) begin
      @(negedge clk);
      scramble();
    end
    start_op(ONES, 53'h80, 1'b1);
    finish_op(ONES, 53'h80, 1'b1, "R7 restart-quick");

    // R1: reset in the middle of a run.
    start_op(ONES, ONES, 1'b0);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && product == '0, "R1", "reset mid-run", product, '0);
    rst_n = 1'b1;
    repeat (60) @(negedge clk);
    chk(done == 1'b0 && product == '0, "R1", "no resume after reset", product, '0);

    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

endmodule